// File: doc/BRIEF.md
# UART Interrupt Status Word Logic

This block builds the interrupt identification byte for one serial channel. It collects requests from the receive path, the line-error detector, the transmit holding stage, the modem-status detector, the software flow-control character comparators and the two hardware flow-control lines. It selects the most urgent of them and presents one 8-bit word for the host to read. The same logic drives an active-high interrupt request.

Level sources such as receive data, line errors and modem change follow their inputs directly. The transmit-empty, Xoff, special-character and flow-edge conditions are held in sticky flags. Each sticky flag has its own clearing rule. A one-cycle read strobe from the bus decode tells the block that the host has read the word, and some flags clear on that read.

Top module: `uart_irq_status`

## Requirements
- R1: With nothing pending, `stat_o` reads 0x01 plus the FIFO bits, and `irq_o` is 0. This is also the state out of reset.
- R2: `stat_o[7]` and `stat_o[6]` both equal `fifo_en_i`.
- R3: `stat_o[3:1]` holds the code of the highest pending source. The order is: line error (011), receive timeout (110), receive data (010), transmit empty (001), modem change (000), and last the Xoff/special or flow-edge conditions (000). `stat_o[0]` is 0 whenever any source is pending.
- R4: A level source counts only while its enable input is 1.
- R5: An Xoff match sets `stat_o[4]`. That status clears on any read strobe, or when an Xon match arrives.
- R6: A special-character match sets `stat_o[4]`. A read strobe leaves it set. It clears when the next character-received pulse arrives without a new match.
- R7: While `enh_en_i` is 0, `stat_o[4]` and `stat_o[5]` read 0, and match or edge events are not retained.
- R8: The transmit-empty flag is set by `tx_empty_i`. A read clears it only when the word read shows code 001. A read showing any other code leaves it set, and `tx_load_i` also clears it.
- R9: A low-to-high transition on `cts_n_i` or `rts_n_i` sets `stat_o[5]`. A high-to-low transition does not. A read strobe clears it.
- R10: `irq_o` is 1 exactly when `stat_o[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_stat_i | input | 1 | One-cycle pulse when the host reads the status word |
| fifo_en_i | input | 1 | FIFOs enabled |
| enh_en_i | input | 1 | Enhanced-feature enable for bits 4 and 5 |
| ien_rx_i | input | 1 | Enable for receive data and timeout |
| ien_line_i | input | 1 | Enable for line errors |
| ien_tx_i | input | 1 | Enable for transmit empty |
| ien_modem_i | input | 1 | Enable for modem change |
| ien_xoff_i | input | 1 | Enable for Xoff/special status |
| ien_flow_i | input | 1 | Enable for flow-line edge status |
| line_err_i | input | 1 | Line error present (level) |
| rx_ready_i | input | 1 | Receive data available (level) |
| rx_timeout_i | input | 1 | Receive timeout (level) |
| modem_chg_i | input | 1 | Modem status change (level) |
| tx_empty_i | input | 1 | Pulse when the transmit holding stage empties |
| tx_load_i | input | 1 | Pulse when the host loads the transmit holding stage |
| xoff_match_i | input | 1 | Pulse on an Xoff character match |
| xon_match_i | input | 1 | Pulse on an Xon character match |
| spec_match_i | input | 1 | Pulse on a special-character match |
| rx_char_i | input | 1 | Pulse for each character received |
| cts_n_i | input | 1 | CTS# line level |
| rts_n_i | input | 1 | RTS# line level |
| stat_o | output | 8 | Interrupt status word |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a read strobe that lands while transmit-empty is pending but hidden under a higher source. In that case the flag must survive the read. The bench holds a line error together with a latched transmit-empty, reads the word, then drops the line error and checks that code 001 appears. A second read must then clear it. The special-character rule is also delicate, because the matching character and its own received pulse arrive together. The bench pulses both in the same cycle, and only a later character pulse may clear the status.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  typedef enum logic [2:0] {
    SRC_MODEM = 3'b000,
    SRC_TX    = 3'b001,
    SRC_RXD   = 3'b010,
    SRC_LINE  = 3'b011,
    SRC_RXTO  = 3'b110
  } src_code_e;

  typedef struct packed {
    logic line;
    logic rxto;
    logic rxd;
    logic tx;
    logic modem;
    logic xs;
    logic flow;
  } src_req_t;

  localparam int unsigned STAT_W = 8;
endpackage

// File: rtl/uirq_edge_det.sv
module uirq_edge_det #(
  parameter int unsigned N_LINES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               en_i,
  input  logic               clr_i,
  output logic               flag_o
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] rise;
  logic               flag_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b1;
      else         prev_q[g] <= lines_i[g];
    end
    assign rise[g] = lines_i[g] & ~prev_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (!en_i)             flag_q <= 1'b0;
    else if (|rise)             flag_q <= 1'b1;
    else if (clr_i)             flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_FLOW_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && |(lines_i & ~prev_q)) |=> flag_o) else $error("flow rise lost"); // R9
  AST_FLOW_FALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !(|(lines_i & ~prev_q))) |=> !flag_o) else $error("flow set w/o rise"); // R9
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic xs_en_i,
  input  logic xoff_i,
  input  logic xon_i,
  input  logic spec_i,
  input  logic rx_char_i,
  input  logic tx_en_i,
  input  logic tx_set_i,
  input  logic tx_load_i,
  input  logic tx_rep_i,
  output logic xs_o,
  output logic tx_o
);
  logic xoff_q, spec_q, tx_q;

  // Xoff: set wins; cleared by any read or by Xon
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           xoff_q <= 1'b0;
    else if (!xs_en_i)     xoff_q <= 1'b0;
    else if (xoff_i)       xoff_q <= 1'b1;
    else if (rd_i || xon_i) xoff_q <= 1'b0;
  end

  // Special char: the matching char carries its own rx_char pulse, so set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         spec_q <= 1'b0;
    else if (!xs_en_i)   spec_q <= 1'b0;
    else if (spec_i)     spec_q <= 1'b1;
    else if (rx_char_i)  spec_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       tx_q <= 1'b0;
    else if (!tx_en_i)                 tx_q <= 1'b0;
    else if (tx_set_i)                 tx_q <= 1'b1;
    else if (tx_load_i || (rd_i && tx_rep_i)) tx_q <= 1'b0;
  end

  assign xs_o = xoff_q | spec_q;
  assign tx_o = tx_q;

  AST_XOFF_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !xoff_i) |=> !xoff_q) else $error("xoff kept over read"); // R5
  AST_SPEC_READ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_q && xs_en_i && !rx_char_i) |=> spec_q) else $error("special lost"); // R6
  AST_TX_HIDDEN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_q && tx_en_i && rd_i && !tx_rep_i && !tx_load_i) |=> tx_q) else $error("tx lost"); // R8
  AST_TX_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && tx_rep_i && !tx_set_i) |=> !tx_q) else $error("tx not cleared"); // R8
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  src_req_t          req_i,
  input  logic              fifo_en_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              pend_o
);
  src_code_e code;

  always_comb begin
    if (req_i.line)       code = SRC_LINE;
    else if (req_i.rxto)  code = SRC_RXTO;
    else if (req_i.rxd)   code = SRC_RXD;
    else if (req_i.tx)    code = SRC_TX;
    else                  code = SRC_MODEM;
  end

  assign pend_o = |req_i;
  assign stat_o = {{2{fifo_en_i}}, req_i.flow, req_i.xs, code, ~pend_o};
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
#(
  parameter int unsigned N_FLOW_LINES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_stat_i,
  input  logic       fifo_en_i,
  input  logic       enh_en_i,
  input  logic       ien_rx_i,
  input  logic       ien_line_i,
  input  logic       ien_tx_i,
  input  logic       ien_modem_i,
  input  logic       ien_xoff_i,
  input  logic       ien_flow_i,
  input  logic       line_err_i,
  input  logic       rx_ready_i,
  input  logic       rx_timeout_i,
  input  logic       modem_chg_i,
  input  logic       tx_empty_i,
  input  logic       tx_load_i,
  input  logic       xoff_match_i,
  input  logic       xon_match_i,
  input  logic       spec_match_i,
  input  logic       rx_char_i,
  input  logic       cts_n_i,
  input  logic       rts_n_i,
  output logic [7:0] stat_o,
  output logic       irq_o
);
  src_req_t          req;
  logic              xs, tx, flow, pend, tx_rep;
  logic [STAT_W-1:0] stat;

  assign tx_rep = (stat[3:1] == SRC_TX) && !stat[0];

  uirq_sticky u_sticky (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_stat_i),
    .xs_en_i   (enh_en_i & ien_xoff_i),
    .xoff_i    (xoff_match_i),
    .xon_i     (xon_match_i),
    .spec_i    (spec_match_i),
    .rx_char_i (rx_char_i),
    .tx_en_i   (ien_tx_i),
    .tx_set_i  (tx_empty_i),
    .tx_load_i (tx_load_i),
    .tx_rep_i  (tx_rep),
    .xs_o      (xs),
    .tx_o      (tx)
  );

  uirq_edge_det #(.N_LINES(N_FLOW_LINES)) u_flow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i ({rts_n_i, cts_n_i}),
    .en_i    (enh_en_i & ien_flow_i),
    .clr_i   (rd_stat_i),
    .flag_o  (flow)
  );

  always_comb begin
    req       = '0;
    req.line  = line_err_i & ien_line_i;
    req.rxto  = rx_timeout_i & ien_rx_i;
    req.rxd   = rx_ready_i & ien_rx_i;
    req.tx    = tx;
    req.modem = modem_chg_i & ien_modem_i;
    req.xs    = xs;
    req.flow  = flow;
  end

  uirq_prio u_prio (
    .req_i     (req),
    .fifo_en_i (fifo_en_i),
    .stat_o    (stat),
    .pend_o    (pend)
  );

  assign stat_o = stat;
  assign irq_o  = pend;

  AST_LINE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_err_i && ien_line_i) |-> (stat_o[3:0] == 4'b0110)) else $error("line not top"); // R3
  AST_ENH_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_en_i |=> (!enh_en_i -> stat_o[5:4] == 2'b00)) else $error("bits 5:4 set"); // R7
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !stat_o[0]) else $error("irq mismatch"); // R10
endmodule

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 0, fifo_en = 0, enh_en = 0;
  logic ien_rx = 0, ien_line = 0, ien_tx = 0, ien_modem = 0, ien_xoff = 0, ien_flow = 0;
  logic line_err = 0, rx_ready = 0, rx_to = 0, modem = 0;
  logic tx_empty = 0, tx_load = 0, xoff = 0, xon = 0, spec = 0, rx_char = 0;
  logic cts_n = 1, rts_n = 1;
  logic [7:0] stat;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_stat_i(rd), .fifo_en_i(fifo_en), .enh_en_i(enh_en),
    .ien_rx_i(ien_rx), .ien_line_i(ien_line), .ien_tx_i(ien_tx), .ien_modem_i(ien_modem),
    .ien_xoff_i(ien_xoff), .ien_flow_i(ien_flow), .line_err_i(line_err), .rx_ready_i(rx_ready),
    .rx_timeout_i(rx_to), .modem_chg_i(modem), .tx_empty_i(tx_empty), .tx_load_i(tx_load),
    .xoff_match_i(xoff), .xon_match_i(xon), .spec_match_i(spec), .rx_char_i(rx_char),
    .cts_n_i(cts_n), .rts_n_i(rts_n), .stat_o(stat), .irq_o(irq)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    finish_run();
  end

  // pulses driven at negedge are seen by one posedge, then dropped
  task automatic tick();
    @(posedge clk); @(negedge clk);
    rd = 0; tx_empty = 0; tx_load = 0; xoff = 0; xon = 0; spec = 0; rx_char = 0;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (stat !== exp || irq !== ~exp[0]) begin
      n_fail++;
      $display("FAIL %s: act stat=%02h irq=%b exp stat=%02h irq=%b", req, stat, irq, exp, ~exp[0]);
    end
  endtask

  task automatic t_reset();
    check("R1 reset", 8'h01);
    fifo_en = 1; #1; check("R2 fifo on", 8'hC1);
    fifo_en = 0; #1; check("R2 fifo off", 8'h01);
  endtask

  task automatic t_priority();
    ien_rx = 1; ien_line = 1; ien_tx = 1; ien_modem = 1;
    modem = 1; #1; check("R3 modem", 8'h00);
    tx_empty = 1; tick(); check("R3 tx over modem", 8'h02);
    rx_ready = 1; #1; check("R3 rxd over tx", 8'h04);
    rx_to = 1; #1; check("R3 timeout over rxd", 8'h0C);
    line_err = 1; #1; check("R3 line top", 8'h06);
    ien_line = 0; #1; check("R4 line masked", 8'h0C);
    ien_rx = 0; #1; check("R4 rx masked", 8'h02);
    tx_load = 1; tick(); check("R8 load clears tx", 8'h00);
    modem = 0; line_err = 0; rx_ready = 0; rx_to = 0; ien_rx = 0; ien_line = 1; #1;
    check("R1 idle again", 8'h01);
  endtask

  task automatic t_tx_read();
    tx_empty = 1; line_err = 1; tick(); check("R8 tx under line", 8'h06);
    rd = 1; tick(); line_err = 0; #1; check("R8 hidden tx survives read", 8'h02);
    rd = 1; tick(); check("R8 read clears tx", 8'h01);
  endtask

  task automatic t_xoff();
    enh_en = 1; ien_xoff = 1;
    xoff = 1; tick(); check("R5 xoff set", 8'h10);
    rd = 1; tick(); check("R5 read clears xoff", 8'h01);
    xoff = 1; tick(); xon = 1; tick(); check("R5 xon clears xoff", 8'h01);
    spec = 1; rx_char = 1; tick(); check("R6 special set", 8'h10);
    rd = 1; tick(); check("R6 read keeps special", 8'h10);
    rx_char = 1; tick(); check("R6 next char clears", 8'h01);
  endtask

  task automatic t_flow();
    ien_flow = 1;
    cts_n = 0; tick(); check("R9 falling no set", 8'h01);
    cts_n = 1; tick(); check("R9 cts rise", 8'h20);
    rd = 1; tick(); check("R9 read clears", 8'h01);
    rts_n = 0; tick(); rts_n = 1; tick(); check("R9 rts rise", 8'h20);
    rd = 1; tick();
    fifo_en = 1; tx_empty = 1; tick(); check("R10 tx with fifo", 8'hC2);
    rd = 1; tick(); fifo_en = 0;
  endtask

  task automatic t_enh_off();
    enh_en = 0;
    xoff = 1; tick(); cts_n = 0; tick(); cts_n = 1; tick();
    check("R7 bits 5:4 off", 8'h01);
    enh_en = 1; #1; check("R7 nothing retained", 8'h01);
  endtask

  initial begin
    #1; t_reset();
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 after reset", 8'h01);
    t_priority();
    t_tx_read();
    t_xoff();
    t_flow();
    t_enh_off();
    finish_run();
  end
endmodule